// File: doc/BRIEF.md
# Pacer-Triggered ADC Acquisition Controller

This block sequences conversions of a sixteen-input analog-to-digital converter and collects the results in a sample FIFO. Software programs it through a small register bus. The bus has byte-wide control registers and a 16-bit read path. Through these registers software selects what starts a conversion: a software strobe, a tick from an external pacer timer, or a rising edge on an external trigger pin. It also selects whether conversions stay on one channel or sweep automatically from channel 0 up to a programmed last channel. Finally, it selects which events raise the two interrupt request lines.

The converter is modelled inside the block as a behavioural handshake. A conversion keeps the busy flag high for a fixed, parameterised number of cycles. It then delivers one 16-bit sample. The sample carries the converted channel, the gain code in force and an 8-bit running conversion count. The count lets software and the bench identify each result. Samples enter a FIFO whose status flags use the polarities listed below. The FIFO is emptied by a specific three-write sequence on its enable bit.

Top module: `adc_acq_ctrl`

## Requirements
- R1: After reset, the status read returns 0x0060. The trigger-mode, interrupt-control and channel registers read 0, and both interrupt lines are low.
- R2: In software mode (trigger-mode bits 1 and 2 both clear), one write to offset 5 starts exactly one conversion. The resulting sample is {channel[15:12], 0[11], gain[10:8], conversion count[7:0]}. The conversion count is the number of conversions completed since reset, modulo 256, including samples that were dropped.
- R3: Busy (status bit 7) is high for exactly CONV_CYCLES cycles, starting at the clock edge that takes the trigger. Any trigger that arrives while busy is high is ignored.
- R4: With trigger-mode bit 1 set, each one-cycle `pacer_tick` pulse starts a conversion. Bit 1 takes priority over bit 2, and software strobes are ignored.
- R5: With only trigger-mode bit 2 set, a rising edge of `ext_trig` starts one conversion. Holding the pin high does not start another, and software strobes are ignored.
- R6: With trigger-mode bit 0 set, the channel register holds the last channel of the scan. Conversions use channels 0, 1, …, last and then wrap to 0. Any write to the channel or trigger-mode register restarts the scan at channel 0.
- R7: With trigger-mode bit 0 clear, every conversion uses the channel written to offset 1.
- R8: Register offsets are: 0 sample read (pops the FIFO), 1 channel, 2 gain write and status read, 3 trigger mode, 4 interrupt control, 5 software strobe, 6 interrupt clear. The trigger-mode register keeps and returns bits 5:0. The status read is {busy[7], full_n[6], half_n[5], not_empty[4], 0[3], gain[2:0]}.
- R9: A write to offset 2 with a code from 0 to 4 in bits 2:0 sets the gain for all later conversions. Codes 5 to 7 are ignored.
- R10: The FIFO holds FIFO_DEPTH (1024) samples. half_n reads 0 when FIFO_DEPTH/2 or more samples are held, and 1 below that.
- R11: A sample produced while the FIFO is full is dropped. full_n then stays 0 until the next FIFO reset, even after samples are read.
- R12: Writing interrupt-control bit 2 as 1 and then as 0 empties the FIFO and restores full_n to 1. Setting the bit to 1 alone does not change the FIFO.
- R13: Interrupt-control bit 0 selects the `irq_data` event: 0 is end of conversion, 1 is reaching half-full. Bit 1 selects the `irq_trig` event: 0 is a pacer tick, 1 is an external rising edge. Both lines hold until a write to offset 6. An event in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops FIFO at offset 0) |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| pacer_tick | input | 1 | One-cycle pulse from the pacer timer |
| ext_trig | input | 1 | External trigger level, synchronous to clk |
| irq_data | output | 1 | Conversion or FIFO interrupt request |
| irq_trig | output | 1 | Pacer or external-trigger interrupt request |

## Verification
The assertions assume the following about the inputs:
- `ext_trig` is already synchronous to `clk`.
- `pacer_tick` is a single-cycle pulse.
- Software does not rewrite the channel register in the middle of a scan conversion.

The stimulus satisfies these assumptions in three ways:
- Every input is driven on the falling clock edge.
- Ticks are pulsed for one cycle.
- Each channel or mode change is made only after the previous conversion has finished.

// File: rtl/acq_pkg.sv
`timescale 1ns/1ps
// Package: shared offsets, field layouts and types of the acquisition controller.
// Assumes a 3-bit register offset and 16-bit samples.
package acq_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 16;
    localparam int GAIN_W = 3;
    localparam logic [GAIN_W-1:0] GAIN_MAX = 3'd4;

    localparam logic [ADDR_W-1:0] A_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] A_CHAN = 3'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
    localparam logic [ADDR_W-1:0] A_TRIG = 3'd3;
    localparam logic [ADDR_W-1:0] A_ICTL = 3'd4;
    localparam logic [ADDR_W-1:0] A_SOFT = 3'd5;
    localparam logic [ADDR_W-1:0] A_ICLR = 3'd6;

    typedef enum logic [1:0] {
        SRC_SOFT  = 2'd0,
        SRC_PACER = 2'd1,
        SRC_EXT   = 2'd2
    } trig_src_e;

    // Trigger-mode register, bit 5 down to bit 0.
    typedef struct packed {
        logic evt_flag;
        logic post_trig;
        logic pre_trig;
        logic ext_sel;
        logic pacer_sel;
        logic scan_en;
    } trig_mode_t;

    // Interrupt-control register, bit 3 down to bit 0.
    typedef struct packed {
        logic isc2;
        logic fifo_en;
        logic isc1;
        logic isc0;
    } int_ctl_t;
endpackage

// File: rtl/acq_regs.sv
`timescale 1ns/1ps
// Module: acq_regs
// Decodes bus writes into the control registers and produces the strobes
// for software trigger, interrupt clear, scan restart and FIFO clear.
// Assumes at most one bus write per cycle and CH_W <= 8.
module acq_regs
    import acq_pkg::*;
#(
    parameter int CH_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output trig_mode_t        trig_mode,
    output int_ctl_t          int_ctl,
    output logic [CH_W-1:0]   chan_reg,
    output logic [GAIN_W-1:0] gain,
    output logic              soft_strobe,
    output logic              iclr_strobe,
    output logic              scan_restart,
    output logic              fifo_clear
);
    logic wr_chan;
    logic wr_gain;
    logic wr_trig;
    logic wr_ictl;
    logic unused_wdata;

    // Address decode of the write strobe.
    always_comb begin
        wr_chan = bus_wr && (bus_addr == A_CHAN);
        wr_gain = bus_wr && (bus_addr == A_STAT);
        wr_trig = bus_wr && (bus_addr == A_TRIG);
        wr_ictl = bus_wr && (bus_addr == A_ICTL);
    end

    assign soft_strobe  = bus_wr && (bus_addr == A_SOFT);
    assign iclr_strobe  = bus_wr && (bus_addr == A_ICLR);
    assign scan_restart = wr_chan || wr_trig;
    // FIFO clear: the enable bit falls, which completes a 0->1->0 sequence.
    assign fifo_clear   = wr_ictl && int_ctl.fifo_en && !bus_wdata[2];
    assign unused_wdata = ^bus_wdata[7:6];

    // Register storage; out-of-range gain codes leave the gain unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_mode <= '0;
            int_ctl   <= '0;
            chan_reg  <= '0;
            gain      <= '0;
        end else begin
            if (wr_chan) chan_reg <= bus_wdata[CH_W-1:0];
            if (wr_gain && (bus_wdata[GAIN_W-1:0] <= GAIN_MAX)) gain <= bus_wdata[GAIN_W-1:0];
            if (wr_trig) trig_mode <= trig_mode_t'(bus_wdata[5:0]);
            if (wr_ictl) int_ctl <= int_ctl_t'(bus_wdata[3:0]);
        end
    end
endmodule

// File: rtl/acq_scan.sv
`timescale 1ns/1ps
// Module: acq_scan
// Selects the conversion start source, steps the scan channel, and models
// the converter as a fixed-length busy window that ends in one sample.
// Assumes pacer_tick is a one-cycle pulse and ext_trig is synchronous.
module acq_scan
    import acq_pkg::*;
#(
    parameter int NUM_CH      = 16,
    parameter int CONV_CYCLES = 4,
    parameter int CH_W        = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_en,
    input  logic              pacer_sel,
    input  logic              ext_sel,
    input  logic [CH_W-1:0]   chan_reg,
    input  logic [GAIN_W-1:0] gain,
    input  logic              soft_strobe,
    input  logic              pacer_tick,
    input  logic              ext_trig,
    input  logic              scan_restart,
    output logic              busy,
    output logic              conv_done,
    output logic [DATA_W-1:0] sample,
    output logic              ext_edge,
    output logic [CH_W-1:0]   scan_pos
);
    localparam int CNT_W = $clog2(CONV_CYCLES + 1);
    localparam int SEQ_W = DATA_W - CH_W - 1 - GAIN_W;

    trig_src_e         src;
    logic              start_req;
    logic              start;
    logic              ext_q;
    logic [CNT_W-1:0]  cnt;
    logic [CH_W-1:0]   conv_ch;
    logic [GAIN_W-1:0] conv_gain;
    logic [SEQ_W-1:0]  seq;

    // Start-source selection; the pacer bit outranks the external bit.
    always_comb begin
        if (pacer_sel)    src = SRC_PACER;
        else if (ext_sel) src = SRC_EXT;
        else              src = SRC_SOFT;
        case (src)
            SRC_PACER: start_req = pacer_tick;
            SRC_EXT:   start_req = ext_edge;
            default:   start_req = soft_strobe;
        endcase
    end

    assign ext_edge  = ext_trig && !ext_q;
    assign start     = start_req && !busy;
    assign conv_done = busy && (cnt == '0);
    assign sample    = {conv_ch, 1'b0, conv_gain, seq};

    // Previous level of the external trigger, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= ext_trig;
    end

    // Converter stub: latch channel and gain, hold busy for CONV_CYCLES cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            cnt       <= '0;
            conv_ch   <= '0;
            conv_gain <= '0;
        end else if (start) begin
            busy      <= 1'b1;
            cnt       <= CNT_W'(CONV_CYCLES - 1);
            conv_ch   <= scan_en ? scan_pos : chan_reg;
            conv_gain <= gain;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    // Running conversion count carried in each sample.
    always_ff @(posedge clk) begin
        if (!rst_n)         seq <= '0;
        else if (conv_done) seq <= seq + 1'b1;
    end

    // Scan position: 0..last, then wraps; restarts on a mode or channel write.
    always_ff @(posedge clk) begin
        if (!rst_n || scan_restart) begin
            scan_pos <= '0;
        end else if (conv_done && scan_en) begin
            scan_pos <= (scan_pos >= chan_reg) ? '0 : scan_pos + 1'b1;
        end
    end
endmodule

// File: rtl/acq_fifo.sv
`timescale 1ns/1ps
// Module: acq_fifo
// Sample FIFO with half-full and sticky full flags. A push into a full FIFO
// is dropped. Clear empties it and drops the sticky flag.
// Assumes DEPTH is a power of two.
module acq_fifo #(
    parameter int DEPTH = 1024,
    parameter int W     = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic [AW:0]  count,
    output logic         full_seen,
    output logic         half_full,
    output logic         not_empty,
    output logic         half_rise
);
    localparam logic [AW:0] FULL_C = (AW+1)'(DEPTH);
    localparam logic [AW:0] HALF_C = (AW+1)'(DEPTH / 2);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic          push_ok;
    logic          pop_ok;
    logic [AW:0]   count_nxt;

    // Accepted operations and next occupancy.
    always_comb begin
        push_ok   = push && (count != FULL_C);
        pop_ok    = pop && (count != '0);
        count_nxt = count;
        if (push_ok && !pop_ok)      count_nxt = count + 1'b1;
        else if (!push_ok && pop_ok) count_nxt = count - 1'b1;
    end

    assign head      = mem[rptr];
    assign half_full = (count >= HALF_C);
    assign not_empty = (count != '0);
    assign half_rise = !clear && (count < HALF_C) && (count_nxt >= HALF_C);

    // Sample storage.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= push_data;
    end

    // Pointers and occupancy, cleared by reset or the FIFO clear sequence.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= wptr + 1'b1;
            if (pop_ok)  rptr <= rptr + 1'b1;
            count <= count_nxt;
        end
    end

    // Sticky full flag: set on reaching DEPTH, dropped only by a clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)        full_seen <= 1'b0;
        else if (count_nxt == FULL_C) full_seen <= 1'b1;
    end
endmodule

// File: rtl/acq_irq.sv
`timescale 1ns/1ps
// Module: acq_irq
// Selects the event behind each interrupt line and holds the request until
// the clear strobe. A new event in the clear cycle wins.
// Assumes event inputs are single-cycle pulses.
module acq_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_half,
    input  logic sel_ext,
    input  logic conv_done,
    input  logic half_rise,
    input  logic pacer_tick,
    input  logic ext_edge,
    input  logic iclr,
    output logic irq_data,
    output logic irq_trig
);
    logic ev_data;
    logic ev_trig;

    // Event selection for each line.
    always_comb begin
        ev_data = sel_half ? half_rise : conv_done;
        ev_trig = sel_ext ? ext_edge : pacer_tick;
    end

    // Request latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_data <= 1'b0;
            irq_trig <= 1'b0;
        end else begin
            if (ev_data)   irq_data <= 1'b1;
            else if (iclr) irq_data <= 1'b0;
            if (ev_trig)   irq_trig <= 1'b1;
            else if (iclr) irq_trig <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_acq_ctrl.sv
`timescale 1ns/1ps
// Module: adc_acq_ctrl (top)
// Register-mapped acquisition controller. It ties the register decode, the
// scan/converter sequencer, the sample FIFO and the interrupt logic together,
// and multiplexes the read path. Reading offset 0 with bus_rd pops the FIFO.
// Assumes synchronous inputs and at most one bus access per cycle.
module adc_acq_ctrl
    import acq_pkg::*;
#(
    parameter int NUM_CH      = 16,
    parameter int CONV_CYCLES = 4,
    parameter int FIFO_DEPTH  = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pacer_tick,
    input  logic              ext_trig,
    output logic              irq_data,
    output logic              irq_trig
);
    localparam int CH_W = $clog2(NUM_CH);
    localparam int AW   = $clog2(FIFO_DEPTH);

    trig_mode_t        trig_mode;
    int_ctl_t          int_ctl;
    logic [CH_W-1:0]   chan_reg;
    logic [GAIN_W-1:0] gain;
    logic              soft_strobe;
    logic              iclr_strobe;
    logic              scan_restart;
    logic              fifo_clear;
    logic              conv_busy;
    logic              conv_done;
    logic [DATA_W-1:0] sample;
    logic              ext_edge;
    logic [CH_W-1:0]   scan_pos;
    logic              fifo_pop;
    logic [DATA_W-1:0] fifo_head;
    logic [AW:0]       fifo_count;
    logic              full_seen;
    logic              half_full;
    logic              not_empty;
    logic              half_rise;

    assign fifo_pop = bus_rd && (bus_addr == A_DATA);

    acq_regs #(.CH_W(CH_W)) regs_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .trig_mode    (trig_mode),
        .int_ctl      (int_ctl),
        .chan_reg     (chan_reg),
        .gain         (gain),
        .soft_strobe  (soft_strobe),
        .iclr_strobe  (iclr_strobe),
        .scan_restart (scan_restart),
        .fifo_clear   (fifo_clear)
    );

    acq_scan #(.NUM_CH(NUM_CH), .CONV_CYCLES(CONV_CYCLES), .CH_W(CH_W)) scan_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .scan_en      (trig_mode.scan_en),
        .pacer_sel    (trig_mode.pacer_sel),
        .ext_sel      (trig_mode.ext_sel),
        .chan_reg     (chan_reg),
        .gain         (gain),
        .soft_strobe  (soft_strobe),
        .pacer_tick   (pacer_tick),
        .ext_trig     (ext_trig),
        .scan_restart (scan_restart),
        .busy         (conv_busy),
        .conv_done    (conv_done),
        .sample       (sample),
        .ext_edge     (ext_edge),
        .scan_pos     (scan_pos)
    );

    acq_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W), .AW(AW)) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (fifo_clear),
        .push      (conv_done),
        .push_data (sample),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .count     (fifo_count),
        .full_seen (full_seen),
        .half_full (half_full),
        .not_empty (not_empty),
        .half_rise (half_rise)
    );

    acq_irq irq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_half   (int_ctl.isc0),
        .sel_ext    (int_ctl.isc1),
        .conv_done  (conv_done),
        .half_rise  (half_rise),
        .pacer_tick (pacer_tick),
        .ext_edge   (ext_edge),
        .iclr       (iclr_strobe),
        .irq_data   (irq_data),
        .irq_trig   (irq_trig)
    );

    // Read-path multiplexer; status flags are full/half active-low.
    always_comb begin
        case (bus_addr)
            A_DATA:  bus_rdata = fifo_head;
            A_CHAN:  bus_rdata = DATA_W'(chan_reg);
            A_STAT:  bus_rdata = {8'h00, conv_busy, ~full_seen, ~half_full, not_empty, 1'b0, gain};
            A_TRIG:  bus_rdata = DATA_W'(trig_mode);
            A_ICTL:  bus_rdata = DATA_W'(int_ctl);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/adc_acq_ctrl_chk.sv
`timescale 1ns/1ps
// Module: adc_acq_ctrl_chk
// Property checker bound to adc_acq_ctrl. It counts busy run length itself so
// that no parameter-sized delay appears in a property.
module adc_acq_ctrl_chk #(
    parameter int CONV_CYCLES = 4,
    parameter int FIFO_DEPTH  = 1024,
    parameter int CH_W        = 4,
    parameter int AW          = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            conv_busy,
    input logic            conv_done,
    input logic [CH_W-1:0] scan_pos,
    input logic [CH_W-1:0] chan_reg,
    input logic [AW:0]     fifo_count,
    input logic            fifo_pop,
    input logic            fifo_clear,
    input logic            full_seen,
    input logic            iclr,
    input logic            half_rise,
    input logic            irq_data
);
    localparam logic [AW:0] FULL_C = (AW+1)'(FIFO_DEPTH);

    logic [15:0] run_len;

    // Length of the current busy run, in cycles before this one.
    always_ff @(posedge clk) begin
        if (!rst_n)         run_len <= '0;
        else if (conv_busy) run_len <= run_len + 1'b1;
        else                run_len <= '0;
    end

    p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> (run_len == 16'(CONV_CYCLES - 1)));

    p_scan_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        scan_pos <= chan_reg);

    p_fifo_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= FULL_C);

    p_drop_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count == FULL_C && !fifo_pop && !fifo_clear) |=> (fifo_count == FULL_C));

    p_fifo_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clear |=> (fifo_count == '0 && !full_seen));

    p_irq_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (iclr && !conv_done && !half_rise) |=> !irq_data);
endmodule

bind adc_acq_ctrl adc_acq_ctrl_chk #(
    .CONV_CYCLES (CONV_CYCLES),
    .FIFO_DEPTH  (FIFO_DEPTH),
    .CH_W        (CH_W),
    .AW          (AW)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_busy  (conv_busy),
    .conv_done  (conv_done),
    .scan_pos   (scan_pos),
    .chan_reg   (chan_reg),
    .fifo_count (fifo_count),
    .fifo_pop   (fifo_pop),
    .fifo_clear (fifo_clear),
    .full_seen  (full_seen),
    .iclr       (iclr_strobe),
    .half_rise  (half_rise),
    .irq_data   (irq_data)
);

// File: tb/adc_acq_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench for adc_acq_ctrl. It sweeps channels, gains and scan lengths, and
// fills the FIFO past full. Expected samples come from a running count.
module adc_acq_ctrl_tb_top;
    localparam int CONV  = 4;
    localparam int DEPTH = 1024;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic        bus_rd;
    logic [2:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic [15:0] bus_rdata;
    logic        pacer_tick;
    logic        ext_trig;
    logic        irq_data;
    logic        irq_trig;

    int checks   = 0;
    int errors   = 0;
    int exp_seq  = 0;
    int exp_gain = 0;
    logic [15:0] d;

    always #10 clk = ~clk;

    adc_acq_ctrl #(.NUM_CH(16), .CONV_CYCLES(CONV), .FIFO_DEPTH(DEPTH)) dut_i (
        .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_rd (bus_rd),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .pacer_tick (pacer_tick), .ext_trig (ext_trig),
        .irq_data (irq_data), .irq_trig (irq_trig)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] smp(input int ch, input int g, input int s);
        return {ch[3:0], 1'b0, g[2:0], s[7:0]};
    endfunction

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(posedge clk); #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 v = bus_rdata;
        @(posedge clk); #1 bus_rd = 1'b0;
    endtask

    task automatic convert();
        wr(3'd5, 8'h00);
        repeat (CONV + 1) @(posedge clk);
        exp_seq++;
    endtask

    task automatic pulse_pacer();
        @(negedge clk); pacer_tick = 1'b1;
        @(posedge clk); #1 pacer_tick = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int first;
        int lasts [5] = '{0, 1, 2, 5, 15};
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        pacer_tick = 1'b0; ext_trig = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset values
        rd(3'd2, d); check("R1 status", d, 16'h0060);
        rd(3'd3, d); check("R1 trigger mode", d, 16'h0000);
        rd(3'd4, d); check("R1 int control", d, 16'h0000);
        rd(3'd1, d); check("R1 channel", d, 16'h0000);
        check("R1 irq lines", {14'b0, irq_data, irq_trig}, 16'h0000);

        wr(3'd1, 8'd5); wr(3'd2, 8'd2); exp_gain = 2;

        // R3 busy window after a software strobe (R2 single conversion)
        wr(3'd5, 8'h00);
        bus_rd = 1'b1; bus_addr = 3'd2;
        for (int i = 0; i < CONV + 2; i++) begin
            @(negedge clk); #1 check("R3 busy window", {15'b0, bus_rdata[7]}, (i < CONV) ? 16'd1 : 16'd0);
        end
        bus_rd = 1'b0;
        rd(3'd0, d); check("R2 sample format", d, smp(5, 2, exp_seq)); exp_seq++;
        rd(3'd2, d); check("R8 status after drain", d, 16'h0062);

        // R3 triggers during busy are ignored
        wr(3'd5, 8'h00); wr(3'd5, 8'h00); wr(3'd5, 8'h00);
        repeat (CONV + 2) @(posedge clk);
        rd(3'd0, d); check("R3 one sample", d, smp(5, 2, exp_seq)); exp_seq++;
        rd(3'd2, d); check("R3 no extra sample", d, 16'h0062);

        // R4 pacer mode
        wr(3'd3, 8'h02);
        wr(3'd5, 8'h00); repeat (CONV + 2) @(posedge clk);
        rd(3'd2, d); check("R4 soft strobe ignored", d, 16'h0062);
        pulse_pacer(); pulse_pacer(); repeat (CONV + 2) @(posedge clk);
        rd(3'd0, d); check("R4 pacer sample", d, smp(5, 2, exp_seq)); exp_seq++;
        rd(3'd2, d); check("R4 busy tick ignored", d, 16'h0062);
        wr(3'd3, 8'h06);
        @(negedge clk) ext_trig = 1'b1; repeat (CONV + 2) @(posedge clk);
        rd(3'd2, d); check("R4 pacer outranks external", d, 16'h0062);
        @(negedge clk) ext_trig = 1'b0;
        pulse_pacer(); repeat (CONV + 2) @(posedge clk);
        rd(3'd0, d); check("R4 pacer with both bits", d, smp(5, 2, exp_seq)); exp_seq++;

        // R5 external edge mode
        wr(3'd3, 8'h04);
        @(negedge clk) ext_trig = 1'b1; repeat (20) @(posedge clk);
        rd(3'd0, d); check("R5 edge sample", d, smp(5, 2, exp_seq)); exp_seq++;
        rd(3'd2, d); check("R5 held level no retrigger", d, 16'h0062);
        wr(3'd5, 8'h00); repeat (CONV + 2) @(posedge clk);
        rd(3'd2, d); check("R5 soft strobe ignored", d, 16'h0062);
        @(negedge clk) ext_trig = 1'b0; repeat (3) @(posedge clk);
        @(negedge clk) ext_trig = 1'b1; repeat (CONV + 3) @(posedge clk);
        rd(3'd0, d); check("R5 second edge", d, smp(5, 2, exp_seq)); exp_seq++;
        @(negedge clk) ext_trig = 1'b0;

        // R8 trigger-mode readback keeps six bits
        wr(3'd3, 8'hF8); rd(3'd3, d); check("R8 trigger readback", d, 16'h0038);
        wr(3'd3, 8'h00);

        // R7 single-channel sweep
        for (int ch = 0; ch < 16; ch++) begin
            wr(3'd1, 8'(ch)); convert();
            rd(3'd0, d); check("R7 channel select", d, smp(ch, exp_gain, exp_seq - 1));
        end

        // R9 gain sweep, codes above 4 ignored
        for (int g = 0; g < 8; g++) begin
            wr(3'd2, 8'(g));
            if (g <= 4) exp_gain = g;
            rd(3'd2, d); check("R9 gain status", d, 16'h0060 | 16'(exp_gain));
            convert();
            rd(3'd0, d); check("R9 gain in sample", d, smp(15, exp_gain, exp_seq - 1));
        end

        // R6 auto-scan over several last-channel values
        foreach (lasts[j]) begin
            wr(3'd1, 8'(lasts[j])); wr(3'd3, 8'h01);
            for (int k = 0; k < 2 * (lasts[j] + 1) + 1; k++) begin
                convert();
                rd(3'd0, d); check("R6 scan order", d, smp(k % (lasts[j] + 1), exp_gain, exp_seq - 1));
            end
        end
        wr(3'd3, 8'h00);

        // R12 reset sequence with data present
        wr(3'd1, 8'd3); wr(3'd4, 8'h00); convert();
        wr(3'd4, 8'h04);
        rd(3'd2, d); check("R12 enable high alone keeps data", d, 16'h0070 | 16'(exp_gain));
        wr(3'd4, 8'h00);
        rd(3'd2, d); check("R12 fifo emptied", d, 16'h0060 | 16'(exp_gain));

        // R10/R11 fill past full, half-full interrupt source (R13)
        wr(3'd4, 8'h01); wr(3'd6, 8'h00);
        check("R13 cleared before fill", {15'b0, irq_data}, 16'd0);
        first = exp_seq;
        for (int n = 1; n <= DEPTH + 2; n++) begin
            convert();
            if (n == DEPTH / 2 - 1) begin
                rd(3'd2, d); check("R10 below half", d, 16'h0070 | 16'(exp_gain));
                check("R13 no half irq yet", {15'b0, irq_data}, 16'd0);
            end
            if (n == DEPTH / 2) begin
                rd(3'd2, d); check("R10 at half", d, 16'h0050 | 16'(exp_gain));
                check("R13 half irq", {15'b0, irq_data}, 16'd1);
            end
            if (n == DEPTH - 1) begin
                rd(3'd2, d); check("R10 not yet full", d, 16'h0050 | 16'(exp_gain));
            end
            if (n == DEPTH) begin
                rd(3'd2, d); check("R10 full", d, 16'h0010 | 16'(exp_gain));
            end
        end
        for (int k = 0; k < DEPTH; k++) begin
            rd(3'd0, d); check("R11 kept samples", d, smp(3, exp_gain, first + k));
            if (k == 0) begin
                rd(3'd2, d); check("R11 full sticky after read", d, 16'h0010 | 16'(exp_gain));
            end
        end
        rd(3'd2, d); check("R11 empty but full sticky", d, 16'h0020 | 16'(exp_gain));
        wr(3'd4, 8'h04); wr(3'd4, 8'h00);
        rd(3'd2, d); check("R12 flags restored", d, 16'h0060 | 16'(exp_gain));

        // R13 interrupt sources and clear
        wr(3'd6, 8'h00);
        check("R13 both clear", {14'b0, irq_data, irq_trig}, 16'h0000);
        convert();
        check("R13 end of conversion", {15'b0, irq_data}, 16'd1);
        wr(3'd6, 8'h00);
        check("R13 clear data line", {15'b0, irq_data}, 16'd0);
        pulse_pacer(); @(posedge clk); #1;
        check("R13 pacer tick source", {15'b0, irq_trig}, 16'd1);
        wr(3'd6, 8'h00); wr(3'd4, 8'h02);
        pulse_pacer(); @(posedge clk); #1;
        check("R13 pacer not selected", {15'b0, irq_trig}, 16'd0);
        @(negedge clk) ext_trig = 1'b1; @(posedge clk); #1;
        check("R13 external edge source", {15'b0, irq_trig}, 16'd1);

        finish_run();
    end
endmodule